// File: doc/BRIEF.md
# Conversion Clock Source Selector

This block produces the clock that paces a converter's sequencing logic. Two sources are available. One is a free-running on-chip oscillator. The other is an optional clock pin that the board may drive, tie high, or leave to a pull-up. The block starts on the oscillator. It watches the pin for rising edges, counting them with the oscillator clock. When enough edges arrive within a short window, the block hands over to the pin. The selected source passes through a divide-by-two flop, and that flop's output is the conversion clock.

The handover in either direction does not glitch. The outgoing source is gated off only while it is low. The incoming source is enabled only while it is low, and only after the outgoing enable has been seen off through a two-flop synchronizer in the incoming domain. If the pin stops toggling for a timeout period, the block returns to the oscillator. A status output reports when the pin clock drives the divider.

Top module: `clk_src_select`

## Requirements
- R1: While `rst_n` is low, `conv_clk` and `ext_active` are both 0. After reset is released, the oscillator is the selected source.
- R2: If `ext_clk` is held constant, either high or low, the oscillator stays selected. `ext_active` stays 0 and `conv_clk` runs at half the `int_clk` frequency.
- R3: Edge counting starts at the first rising edge on `ext_clk` and lasts `WINDOW_CYC` cycles of `int_clk`. The block switches to `ext_clk` only if `EDGE_COUNT` rising edges (default 16) arrive within that window. Fewer edges, whether from a short burst or from a slow input, cause no switch.
- R4: Once the external source is selected, `ext_active` is 1 and `conv_clk` runs at half the `ext_clk` frequency.
- R5: The two sources never drive the divider at the same time. `ext_active` is 1 only while the oscillator path is gated off, and it stays 0 whenever the oscillator drives.
- R6: If no rising edge is seen on `ext_clk` for `TIMEOUT_CYC` consecutive `int_clk` cycles, the oscillator is selected again and `ext_active` returns to 0. A pause shorter than this does not cause a switch.
- R7: Every high phase and every low phase of `conv_clk` lasts at least one full `int_clk` period, including the phases around a handover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_clk | input | 1 | Free-running on-chip oscillator clock; also clocks the edge detector |
| ext_clk | input | 1 | Optional external clock pin; idles high when unused |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_clk | output | 1 | Selected source divided by two |
| ext_active | output | 1 | 1 while the external source drives the divider |

## Verification
The assertions assume three things about `ext_clk`. Its high and low phases must each span at least two `int_clk` periods, so the synchronizer catches every rising edge. It must be stalled before a timeout removes it. It must not produce `EDGE_COUNT` edges within the few cycles of a handover. The stimulus keeps to these limits. It uses a 60 ns or 400 ns external period against an 8 ns oscillator. Every burst ends with the pin parked high. Each new scenario starts only after any open counting window has expired, so the first counted edge always opens a fresh window.

// File: rtl/clk_src_select.sv
`timescale 1ns/1ps
module clk_src_select #(
  parameter int EDGE_COUNT  = 16,
  parameter int WINDOW_CYC  = 300,
  parameter int TIMEOUT_CYC = 300,
  parameter int SYNC_STAGES = 2
) (
  input  logic int_clk,
  input  logic ext_clk,
  input  logic rst_n,
  output logic conv_clk,
  output logic ext_active
);

  localparam int WIN_W  = $clog2(WINDOW_CYC + 1);
  localparam int EDGE_W = $clog2(EDGE_COUNT + 1);
  localparam int IDLE_W = $clog2(TIMEOUT_CYC + 1);

  // edge detection in the oscillator domain
  logic [SYNC_STAGES:0] ext_smp;
  logic                 ext_rise;

  always_ff @(posedge int_clk or negedge rst_n)
    if (!rst_n) ext_smp <= '1;
    else        ext_smp <= {ext_smp[SYNC_STAGES-1:0], ext_clk};

  assign ext_rise = ext_smp[SYNC_STAGES-1] & ~ext_smp[SYNC_STAGES];

  logic              want_ext, hunting;
  logic [WIN_W-1:0]  win_cnt;
  logic [EDGE_W-1:0] edge_cnt;
  logic [IDLE_W-1:0] idle_cnt;

  always_ff @(posedge int_clk or negedge rst_n) begin
    if (!rst_n) begin
      want_ext <= 1'b0;
      hunting  <= 1'b0;
      win_cnt  <= '0;
      edge_cnt <= '0;
      idle_cnt <= '0;
    end else if (!want_ext) begin
      if (!hunting) begin
        if (ext_rise) begin
          hunting  <= 1'b1;
          edge_cnt <= EDGE_W'(1);
          win_cnt  <= '0;
        end
      end else if (ext_rise && edge_cnt == EDGE_W'(EDGE_COUNT - 1)) begin
        want_ext <= 1'b1;
        hunting  <= 1'b0;
        idle_cnt <= '0;
      end else if (win_cnt == WIN_W'(WINDOW_CYC - 1)) begin
        hunting <= 1'b0;
      end else begin
        win_cnt <= win_cnt + 1'b1;
        if (ext_rise) edge_cnt <= edge_cnt + 1'b1;
      end
    end else begin
      if (ext_rise)                                 idle_cnt <= '0;
      else if (idle_cnt == IDLE_W'(TIMEOUT_CYC - 1)) want_ext <= 1'b0;
      else                                          idle_cnt <= idle_cnt + 1'b1;
    end
  end

  // glitch-free handover: each enable moves on its own clock's falling edge
  logic                   int_en, ext_en, ext_clr;
  logic [SYNC_STAGES-1:0] ext_en_s;
  logic [SYNC_STAGES-1:0] int_en_s;

  always_ff @(negedge int_clk or negedge rst_n)
    if (!rst_n) begin
      ext_en_s <= '0;
      int_en   <= 1'b0;
    end else begin
      ext_en_s <= {ext_en_s[SYNC_STAGES-2:0], ext_en};
      int_en   <= ~want_ext & ~ext_en_s[SYNC_STAGES-1];
    end

  always_ff @(negedge ext_clk or negedge rst_n)
    if (!rst_n) int_en_s <= '1;
    else        int_en_s <= {int_en_s[SYNC_STAGES-2:0], int_en};

  // a stalled pin cannot clock its own enable off, so it is cleared directly
  assign ext_clr = ~rst_n | ~want_ext;

  always_ff @(negedge ext_clk or posedge ext_clr)
    if (ext_clr) ext_en <= 1'b0;
    else         ext_en <= ~int_en_s[SYNC_STAGES-1];

  logic mux_clk, div_q;
  assign mux_clk = (int_clk & int_en) | (ext_clk & ext_en);

  always_ff @(posedge mux_clk or negedge rst_n)
    if (!rst_n) div_q <= 1'b0;
    else        div_q <= ~div_q;

  assign conv_clk   = div_q;
  assign ext_active = ext_en_s[SYNC_STAGES-1];

endmodule

// File: rtl/clk_src_select_chk.sv
`timescale 1ns/1ps
module clk_src_select_chk #(
  parameter int TIMEOUT_CYC = 300
) (
  input logic int_clk,
  input logic rst_n,
  input logic int_en,
  input logic ext_en,
  input logic want_ext,
  input logic ext_rise,
  input logic ext_active
);
  localparam int QW = $clog2(TIMEOUT_CYC + 2);
  logic [QW-1:0] quiet;

  always_ff @(posedge int_clk or negedge rst_n)
    if (!rst_n)                   quiet <= '0;
    else if (ext_rise || !want_ext) quiet <= '0;
    else                          quiet <= quiet + 1'b1;

  AST_ONE_SOURCE: assert property (@(posedge int_clk) disable iff (!rst_n)
    !(int_en && ext_en)); // R5
  AST_STATUS_GATED: assert property (@(posedge int_clk) disable iff (!rst_n)
    ext_active |-> !int_en); // R5
  AST_SWITCH_ON_EDGE: assert property (@(posedge int_clk) disable iff (!rst_n)
    $rose(want_ext) |-> $past(ext_rise)); // R3
  AST_FALLBACK_QUIET: assert property (@(posedge int_clk) disable iff (!rst_n)
    $fell(want_ext) |-> !$past(ext_rise)); // R6
  AST_TIMEOUT_BOUND: assert property (@(posedge int_clk) disable iff (!rst_n)
    want_ext |-> (quiet < QW'(TIMEOUT_CYC))); // R6
endmodule

bind clk_src_select clk_src_select_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .int_clk(int_clk), .rst_n(rst_n), .int_en(int_en), .ext_en(ext_en),
  .want_ext(want_ext), .ext_rise(ext_rise), .ext_active(ext_active));

// File: tb/clk_src_select_bench.sv
`timescale 1ns/1ps
module clk_src_select_bench;
  logic int_clk = 1'b0, ext_clk = 1'b1, rst_n = 1'b0;
  logic conv_clk, ext_active;
  int n_chk = 0, n_fail = 0;
  bit  ext_run = 1'b0, done = 1'b0;
  int  conv_edges = 0, ext_edges = 0, phase_bad = 0;
  realtime ext_half = 30.0, last_t = 0.0;

  clk_src_select u_clk_src_select (
    .int_clk(int_clk), .ext_clk(ext_clk), .rst_n(rst_n),
    .conv_clk(conv_clk), .ext_active(ext_active));

  always #4 int_clk = ~int_clk;

  always begin
    if (ext_run) begin #(ext_half) ext_clk = 1'b0; #(ext_half) ext_clk = 1'b1; end
    else #2;
  end

  always @(posedge conv_clk) conv_edges++;
  always @(posedge ext_clk) ext_edges++;
  always @(conv_clk) begin
    if (rst_n && last_t > 0.0 && ($realtime - last_t) < 7.9) phase_bad++;
    last_t = $realtime;
  end

  task automatic chk(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic meas(input int ns, output int n);
    int b = conv_edges;
    #(ns);
    n = conv_edges - b;
  endtask

  task automatic burst(input int n, input realtime half);
    for (int i = 0; i < n; i++) begin #(half) ext_clk = 1'b0; #(half) ext_clk = 1'b1; end
  endtask

  task automatic t_reset;
    #50; @(negedge int_clk);
    chk("R1 conv_clk in reset", int'(conv_clk), 0, 0);
    chk("R1 ext_active in reset", int'(ext_active), 0, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_idle_high;
    int n;
    #1600; @(negedge int_clk);
    chk("R1 R2 status after reset", int'(ext_active), 0, 0);
    meas(1600, n);
    chk("R2 int/2 rate, pin high", n, 98, 102);
  endtask

  task automatic t_idle_low;
    int n;
    @(negedge int_clk); #1 ext_clk = 1'b0;
    #2000; @(negedge int_clk);
    chk("R2 status, pin low", int'(ext_active), 0, 0);
    meas(1600, n);
    chk("R2 int/2 rate, pin low", n, 98, 102);
    ext_clk = 1'b1;
    #3000;
  endtask

  task automatic t_slow;
    ext_half = 200.0; @(negedge int_clk); #1 ext_run = 1'b1;
    #6000; ext_run = 1'b0; #500; @(negedge int_clk);
    chk("R3 slow input no switch", int'(ext_active), 0, 0);
    #3000;
  endtask

  task automatic t_short_burst;
    @(negedge int_clk); #1 burst(15, 30.0);
    #4000; @(negedge int_clk);
    chk("R3 15-edge burst no switch", int'(ext_active), 0, 0);
  endtask

  task automatic t_switch;
    int n, base;
    ext_half = 30.0; base = ext_edges;
    @(negedge int_clk); #1 ext_run = 1'b1;
    while (ext_edges < base + 15) @(posedge ext_clk);
    #10;
    chk("R3 no switch before 16th edge", int'(ext_active), 0, 0);
    while (ext_edges < base + 16) @(posedge ext_clk);
    #600; @(negedge int_clk);
    chk("R3 R5 switched after 16th edge", int'(ext_active), 1, 1);
    meas(2400, n);
    chk("R4 ext/2 rate", n, 18, 22);
    @(negedge int_clk);
    chk("R4 status held in ext mode", int'(ext_active), 1, 1);
  endtask

  task automatic t_timeout;
    int n;
    ext_run = 1'b0;
    #1000; @(negedge int_clk);
    chk("R6 short pause keeps ext", int'(ext_active), 1, 1);
    #3000; @(negedge int_clk);
    chk("R6 R5 fallback status", int'(ext_active), 0, 0);
    meas(1600, n);
    chk("R6 int/2 rate after fallback", n, 98, 102);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_high();
    t_idle_low();
    t_slow();
    t_short_burst();
    t_switch();
    t_timeout();
    chk("R7 minimum conv_clk phase", phase_bad, 0, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule